// File: doc/BRIEF.md
# Virtual processor run-control unit

This unit decides which of several hardware virtual processors (VPs) sharing one core may run. Each VP can ask to freeze all its peers or to release them again. Each VP has a one-bit owner flag, DIS, that records that it currently holds the freeze. A VP that holds the freeze keeps running. A VP that does not hold it runs only while no peer holds the freeze. Each request returns the requester's control word as it stood before the request.

The unit also works out a per-VP "has work" signal. It combines a pending wake with the run permission, so a frozen VP never reports work. A release wakes the peers, except a peer that was already parked in wait-for-interrupt while still allowed to run; that peer stays parked. Two registers per VP can be read and cannot be written: a control word and a global number. One feature-present input gates the whole mechanism.

Requests are strobes. Requests from several VPs in the same cycle are queued. They are served one per cycle, lowest VP index first, and each served request produces a one-cycle response pulse on the next clock edge.

Top module: `vp_runctl`

## Requirements
- R1: After reset every DIS flag is 0, every VP is active, and no response is valid.
- R2: A VP is active when its own DIS flag is set, or when no other VP has DIS set.
- R3: A served freeze request returns the requester's prior control word (bit 0 = DIS) on `rsp_data`. If DIS was clear it then sets DIS, which leaves the requester active and every other VP without DIS inactive. If DIS was already set, the request changes nothing.
- R4: A served release request returns the prior control word. If DIS was clear it changes nothing. If DIS was set it clears DIS.
- R5: A release that clears DIS posts a wake to every other VP, except a VP that was halted (`halted` bit high) and active in the cycle the release was served.
- R6: `has_work[i]` is high only when VP i is active and either `wake_irq[i]` is high or a posted wake is held. It is low for an inactive VP even with `wake_irq` high.
- R7: A posted wake is dropped on any clock edge where the VP's `halted` bit is low. It is also dropped when another VP's freeze request sets that other VP's DIS.
- R8: With `vp_feature` low (the feature bit, bit 7 of the configuration word), requests are still served and acknowledged, but `rsp_data` is 0, no DIS flag or posted wake changes, and `rd_data` reads 0.
- R9: Requests are served one per cycle, lowest VP index first. A request presented before clock edge k, with no lower-index request pending, gives `rsp_valid` one-hot at the requester's bit for exactly the cycle after edge k. The outcome equals strictly sequential execution.
- R10: Reads: `rd_sel`=0 returns the control word of VP `rd_vp` (DIS at bit 0, other bits 0). `rd_sel`=1 returns the global number, which is the VP index in bits 7:0, with the other bits 0.
- R11: A freeze request from a VP that is itself inactive is applied as written: that VP sets its own DIS and becomes active alongside the existing owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vp_feature | input | 1 | Feature-present bit (bit 7 of configuration word) |
| dvp_req | input | NUM_VP | Freeze-others request strobe, one per VP |
| evp_req | input | NUM_VP | Release-others request strobe, one per VP |
| halted | input | NUM_VP | VP is parked in wait-for-interrupt |
| wake_irq | input | NUM_VP | Wake interrupt pending per VP |
| rd_vp | input | IW | VP index for register read |
| rd_sel | input | 1 | 0 = control word, 1 = global number |
| rd_data | output | DW | Read data |
| rsp_valid | output | NUM_VP | One-cycle response pulse, one-hot to requester |
| rsp_data | output | DW | Prior control word of the served request |
| active | output | NUM_VP | Run permission per VP |
| has_work | output | NUM_VP | Wake pending and permitted per VP |

## Verification
The bench targets the release path when a peer is parked and still active. A design that wakes every peer would later report work for that parked VP. A second target is a freeze request from a VP that is already frozen: a design that lets only one owner exist would leave that VP inactive. Simultaneous requests check the serialisation. A design that drops or merges a queued request loses the second response pulse, and one that serves highest-index first pulses the wrong bit. With the feature bit low, a design that still updates DIS shows a changed run permission or a nonzero return value.

// File: rtl/vp_runctl.sv
module vp_runctl #(
  parameter int NUM_VP = 4,
  parameter int DW = 32,
  localparam int IW = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vp_feature,
  input  logic [NUM_VP-1:0] dvp_req,
  input  logic [NUM_VP-1:0] evp_req,
  input  logic [NUM_VP-1:0] halted,
  input  logic [NUM_VP-1:0] wake_irq,
  input  logic [IW-1:0]     rd_vp,
  input  logic              rd_sel,
  output logic [DW-1:0]     rd_data,
  output logic [NUM_VP-1:0] rsp_valid,
  output logic [DW-1:0]     rsp_data,
  output logic [NUM_VP-1:0] active,
  output logic [NUM_VP-1:0] has_work
);

  logic [NUM_VP-1:0] dis, pend, pend_evp, kick;
  logic [NUM_VP-1:0] cand, is_evp, sel_mask;
  logic [IW-1:0]     srv_idx;
  logic              srv_any, srv_evp;

  assign cand    = pend | dvp_req | evp_req;
  assign is_evp  = (pend & pend_evp) | (~pend & evp_req & ~dvp_req);
  assign srv_any = |cand;
  assign srv_evp = is_evp[srv_idx];
  assign sel_mask = NUM_VP'(1) << srv_idx;

  always_comb begin
    srv_idx = '0;
    for (int i = NUM_VP - 1; i >= 0; i--)
      if (cand[i]) srv_idx = IW'(i);
  end

  for (genvar g = 0; g < NUM_VP; g++) begin : g_act
    assign active[g] = dis[g] | ~|(dis & ~(NUM_VP'(1) << g));
  end

  assign has_work = active & (wake_irq | kick);

  assign rd_data = !vp_feature ? '0 :
                   rd_sel      ? DW'(rd_vp) : DW'(dis[rd_vp]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis       <= '0;
      pend      <= '0;
      pend_evp  <= '0;
      kick      <= '0;
      rsp_valid <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= '0;
      pend      <= cand;
      pend_evp  <= is_evp;
      kick      <= kick & halted;
      if (srv_any) begin
        pend[srv_idx]      <= 1'b0;
        rsp_valid[srv_idx] <= 1'b1;
        rsp_data           <= vp_feature ? DW'(dis[srv_idx]) : '0;
        if (vp_feature && !srv_evp && !dis[srv_idx]) begin
          dis[srv_idx] <= 1'b1;
          kick         <= kick & halted & sel_mask;
        end
        if (vp_feature && srv_evp && dis[srv_idx]) begin
          dis[srv_idx] <= 1'b0;
          kick         <= (kick & halted) | (~sel_mask & ~(halted & active));
        end
      end
    end
  end

  a_r2_someone_runs: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(active) != 0);

  a_r3_requester_runs: assert property (@(posedge clk) disable iff (!rst_n)
    srv_any && vp_feature && !srv_evp |=> active[$past(srv_idx)]);

  a_r4_release_returns_set: assert property (@(posedge clk) disable iff (!rst_n)
    srv_any && vp_feature && srv_evp && dis[srv_idx] |=> rsp_data == DW'(1));

  a_r8_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    srv_any && !vp_feature |=> $stable(dis) && rsp_data == '0);

  a_r9_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid));

  a_r9_pulse_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
    srv_any |=> rsp_valid != '0);

endmodule

// File: tb/vp_runctl_tb_top.sv
module vp_runctl_tb_top;
  localparam int N = 4;

  logic clk = 0, rst_n = 0, vp_feature = 1, rd_sel = 0;
  logic [N-1:0] dvp_req = 0, evp_req = 0, halted = 0, wake_irq = 0;
  logic [1:0] rd_vp = 0;
  logic [31:0] rd_data, rsp_data;
  logic [N-1:0] rsp_valid, active, has_work;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  vp_runctl #(.NUM_VP(N), .DW(32)) dut_i (
    .clk, .rst_n, .vp_feature, .dvp_req, .evp_req, .halted, .wake_irq,
    .rd_vp, .rd_sel, .rd_data, .rsp_valid, .rsp_data, .active, .has_work);

  // {freeze, vp[1:0], halted[3:0], exp_rsp, exp_active[3:0], exp_has_work[3:0]}
  localparam logic [15:0] VEC [9] = '{
    {1'b0, 2'd0, 4'b0000, 1'b0, 4'b1111, 4'b0000},
    {1'b1, 2'd1, 4'b0000, 1'b0, 4'b0010, 4'b0000},
    {1'b1, 2'd1, 4'b0000, 1'b1, 4'b0010, 4'b0000},
    {1'b1, 2'd2, 4'b0000, 1'b0, 4'b0110, 4'b0000},
    {1'b0, 2'd1, 4'b1111, 1'b1, 4'b0100, 4'b0000},
    {1'b0, 2'd2, 4'b1111, 1'b1, 4'b1111, 4'b1011},
    {1'b0, 2'd3, 4'b1111, 1'b0, 4'b1111, 4'b1011},
    {1'b1, 2'd0, 4'b1111, 1'b0, 4'b0001, 4'b0001},
    {1'b0, 2'd0, 4'b0000, 1'b1, 4'b1111, 4'b1110}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; dvp_req = 0; evp_req = 0; halted = 0; wake_irq = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic request(logic [N-1:0] fz, logic [N-1:0] rl);
    dvp_req = fz; evp_req = rl;
    @(negedge clk);
    dvp_req = 0; evp_req = 0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state, R10 read map
    check("R1 active", 32'(active), 32'hF);
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    rd_sel = 1; rd_vp = 3; #1;
    check("R10 global number", rd_data, 3);
    rd_sel = 0; rd_vp = 0; #1;
    check("R10 control word", rd_data, 0);

    // Vector walk: R2 R3 R4 R5 R7 R11
    for (int k = 0; k < 9; k++) begin
      logic [15:0] v;
      v = VEC[k];
      halted = v[12:9];
      request(v[15] ? (4'(1) << v[14:13]) : 4'b0, v[15] ? 4'b0 : (4'(1) << v[14:13]));
      check($sformatf("R9 row%0d valid", k), 32'(rsp_valid), 32'(4'(1) << v[14:13]));
      check($sformatf("R3/R4 row%0d rsp", k), rsp_data, 32'(v[8]));
      check($sformatf("R2/R11 row%0d active", k), 32'(active), 32'(v[7:4]));
      check($sformatf("R5/R7 row%0d has_work", k), 32'(has_work), 32'(v[3:0]));
    end

    // R6 gating of wake interrupt by run permission
    do_reset();
    request(4'b0010, 0);
    wake_irq = 4'b1111; #1;
    check("R6 has_work gated", 32'(has_work), 32'h2);
    rd_vp = 1; rd_sel = 0; #1;
    check("R10 control DIS", rd_data, 1);
    wake_irq = 0;

    // R9 simultaneous requests, lowest index first
    do_reset();
    request(4'b0110, 0);
    check("R9 first served", 32'(rsp_valid), 32'h2);
    check("R9 first data", rsp_data, 0);
    @(negedge clk);
    check("R9 second served", 32'(rsp_valid), 32'h4);
    check("R9 second data", rsp_data, 0);
    check("R9 sequential outcome", 32'(active), 32'h6);
    @(negedge clk);
    check("R9 pulse single cycle", 32'(rsp_valid), 0);

    // R8 feature absent
    do_reset();
    vp_feature = 0;
    request(4'b0100, 0);
    check("R8 acked", 32'(rsp_valid), 32'h4);
    check("R8 rsp zero", rsp_data, 0);
    check("R8 active unchanged", 32'(active), 32'hF);
    rd_sel = 1; rd_vp = 3; #1;
    check("R8 read zero", rd_data, 0);
    vp_feature = 1;
    rd_sel = 0; rd_vp = 2; #1;
    check("R8 DIS untouched", rd_data, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule